// File: doc/BRIEF.md
# Linked-Descriptor Word DMA Engine with Row/Stride Mode

This block is a single-channel copy engine. It follows a chain of control blocks kept in system memory. Each control block is six 32-bit words. After a start pulse, the engine reads the first control block through a simple request/ready word master. It then moves 32-bit words from a source address to a destination address. When the block is finished, the engine signals completion and moves on to the next control block named in the one it just ran.

The engine has two copy modes. In the flat mode the whole length word is the byte count. In the row/stride mode a number of rows of equal byte length are copied, and a signed offset is added to each address between rows. The source and the destination each have their own controls: one chooses whether the address steps forward by 4 on every beat, and one chooses whether that side is skipped. A skipped source reads as zero, and a skipped destination drops the write. The live contents of the current control block appear on output ports. The remaining-length field is updated beat by beat.

Top module: `chain_dma`

## Requirements
- R1: While reset is held and after it is released, the engine is idle. In that state busy, mem_req, desc_done, end_flag and irq are all low.
- R2: A start pulse is accepted only when enable is high and first_desc is nonzero. The engine then reads six words, at first_desc+0, +4, +8, +12, +16 and +20, in that order. These are info, source, destination, length, stride and next-pointer. A start with enable low or first_desc zero causes no memory access and busy stays low.
- R3: In flat mode (info bit 1 clear), the length word is a byte count. Each beat reads one word and then writes it. The number of beats is the byte count divided by 4, rounded up. cur_len drops by 4 after each beat, and the last beat takes it to 0. A byte count of 0 makes no beats.
- R4: Info bit 8 set makes the source address step by 4 after each beat. Info bit 4 does the same for the destination. When a bit is clear, that address stays put.
- R5: Info bit 11 set makes the engine skip source reads and use the value zero instead. Info bit 7 set makes it skip destination writes, so destination memory is unchanged.
- R6: In row/stride mode (info bit 1 set), the number of rows is 1 plus length bits 29:16, and each row holds length bits 15:0 bytes. Between rows, a sign-extended value is added to each address: stride bits 15:0 to the source and stride bits 31:16 to the destination. The offset is not added after the last row.
- R7: In row/stride mode, cur_len reads as rows remaining (counting the current row) in bits 31:16 and bytes remaining in the row in bits 15:0. After the final beat it reads 0x0001_0000.
- R8: When a control block finishes, desc_done pulses high for exactly one cycle and end_flag becomes set. If info bit 0 is set, irq also becomes set. Both end_flag and irq are cleared by the next accepted start.
- R9: After each control block, the engine loads the next-pointer into cur_desc_addr. If that value is nonzero, the engine fetches and runs that block. A next-pointer of zero ends the chain and the engine returns to idle.
- R10: If enable is dropped during a control block, that block still runs to completion. The engine then loads the next-pointer but fetches nothing more and goes idle.
- R11: Once mem_req is raised, mem_addr, mem_we and mem_wdata hold steady until a cycle in which mem_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a chain |
| enable | input | 1 | Channel enable, sampled at start and at each block boundary |
| first_desc | input | 32 | Byte address of the first control block |
| busy | output | 1 | High whenever the engine is not idle |
| cur_desc_addr | output | 32 | Address of the current control block |
| cur_info | output | 32 | Info word of the current block |
| cur_src | output | 32 | Live source address |
| cur_dst | output | 32 | Live destination address |
| cur_len | output | 32 | Live remaining length |
| cur_stride | output | 32 | Stride word of the current block |
| cur_next | output | 32 | Next-pointer of the current block |
| desc_done | output | 1 | One-cycle pulse when a block finishes |
| end_flag | output | 1 | Sticky block-finished flag |
| irq | output | 1 | Sticky interrupt line |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access complete in this cycle |

## Verification
The bench's memory model raises mem_ready at a falling edge after 0 to 3 cycles of wait, so every handshake completes at the rising edge that follows. busy is therefore already high at the first falling edge after the start pulse. The flags and the interrupt follow one cycle after the desc_done pulse, so the bench compares memory contents, live registers, flags and beat counts only at the first falling edge where busy reads low again. The bench counts desc_done at every falling edge, which also confirms that the pulse lasts one cycle. It checks that requests are held by comparing the request seen at each falling edge with the one seen at the falling edge before.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_READ, S_WRITE, S_ROWEND, S_DONE, S_NEXT
  } cdma_state_e;

  localparam int DESC_WORDS = 6;

  // info word bit positions
  localparam int IB_IRQ_EN   = 0;
  localparam int IB_ROWMODE  = 1;
  localparam int IB_DST_STEP = 4;
  localparam int IB_DST_SKIP = 7;
  localparam int IB_SRC_STEP = 8;
  localparam int IB_SRC_SKIP = 11;

  // control-block word order
  localparam int W_INFO   = 0;
  localparam int W_SRC    = 1;
  localparam int W_DST    = 2;
  localparam int W_LEN    = 3;
  localparam int W_STRIDE = 4;
  localparam int W_NEXT   = 5;

endpackage

// File: rtl/cdma_geom.sv
module cdma_geom #(
  parameter int DW     = 32,
  parameter int ROW_W  = 16,
  parameter int ROWS_W = 14
) (
  input  logic             row_mode,
  input  logic [DW-1:0]    len_word,
  input  logic [DW-1:0]    stride_word,
  output logic [DW-1:0]    row_bytes,
  output logic [ROW_W-1:0] rows,
  output logic [DW-1:0]    src_off,
  output logic [DW-1:0]    dst_off
);
  localparam int HALF = DW / 2;

  always_comb begin
    if (row_mode) begin
      row_bytes = DW'(len_word[ROW_W-1:0]);
      rows      = ROW_W'(len_word[ROW_W +: ROWS_W]) + ROW_W'(1);
      src_off   = {{HALF{stride_word[HALF-1]}}, stride_word[HALF-1:0]};
      dst_off   = {{HALF{stride_word[DW-1]}}, stride_word[DW-1:HALF]};
    end else begin
      row_bytes = len_word;
      rows      = ROW_W'(1);
      src_off   = '0;
      dst_off   = '0;
    end
  end
endmodule

// File: rtl/cdma_cursor.sv
module cdma_cursor #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          beat,
  input  logic          step_en,
  input  logic          jump,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | jump | (beat & step_en);
    if (load)      addr_d = load_val;
    else if (jump) addr_d = addr + offset;
    else           addr_d = addr + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_d;
  end
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int ROW_W  = 16,
  parameter int ROWS_W = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          enable,
  input  logic [AW-1:0] first_desc,
  output logic          busy,
  output logic [AW-1:0] cur_desc_addr,
  output logic [DW-1:0] cur_info,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [DW-1:0] cur_len,
  output logic [DW-1:0] cur_stride,
  output logic [AW-1:0] cur_next,
  output logic          desc_done,
  output logic          end_flag,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam int BYTES = DW / 8;
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  cdma_state_e      st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    cb_q;
  logic [DW-1:0]    info_q, len_q, stride_q, data_q, xrem_q, row_q;
  logic [AW-1:0]    next_q;
  logic [ROW_W-1:0] yrem_q;
  logic             end_q, irq_q;

  logic             start_ok, fetch_hs, setup, rd_done, beat_done;
  logic             row_jump, src_skip, dst_skip;
  logic [DW-1:0]    xnext, g_row_bytes, g_src_off, g_dst_off;
  logic [ROW_W-1:0] g_rows;

  assign src_skip  = info_q[IB_SRC_SKIP];
  assign dst_skip  = info_q[IB_DST_SKIP];
  assign start_ok  = (st_q == S_IDLE) && start && enable && (first_desc != '0);
  assign fetch_hs  = (st_q == S_FETCH) && mem_ready;
  assign setup     = fetch_hs && (idx_q == IDX_LAST);
  assign rd_done   = (st_q == S_READ) && (src_skip || mem_ready);
  assign beat_done = (st_q == S_WRITE) && (dst_skip || mem_ready);
  assign row_jump  = (st_q == S_ROWEND) && (yrem_q > ROW_W'(1));
  assign xnext     = (xrem_q > DW'(BYTES)) ? xrem_q - DW'(BYTES) : '0;

  cdma_geom #(.DW(DW), .ROW_W(ROW_W), .ROWS_W(ROWS_W)) u_geom (
    .row_mode    (info_q[IB_ROWMODE]),
    .len_word    (len_q),
    .stride_word (stride_q),
    .row_bytes   (g_row_bytes),
    .rows        (g_rows),
    .src_off     (g_src_off),
    .dst_off     (g_dst_off)
  );

  cdma_cursor #(.AW(AW), .STEP(BYTES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fetch_hs && (idx_q == IDX_W'(W_SRC))),
    .load_val (mem_rdata),
    .beat     (rd_done),
    .step_en  (info_q[IB_SRC_STEP]),
    .jump     (row_jump),
    .offset   (g_src_off),
    .addr     (cur_src)
  );

  cdma_cursor #(.AW(AW), .STEP(BYTES)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fetch_hs && (idx_q == IDX_W'(W_DST))),
    .load_val (mem_rdata),
    .beat     (beat_done),
    .step_en  (info_q[IB_DST_STEP]),
    .jump     (row_jump),
    .offset   (g_dst_off),
    .addr     (cur_dst)
  );

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (start_ok) st_d = S_FETCH;
      S_FETCH:  if (setup) st_d = (g_row_bytes != '0) ? S_READ : S_ROWEND;
      S_READ:   if (rd_done) st_d = S_WRITE;
      S_WRITE:  if (beat_done) st_d = (xnext == '0) ? S_ROWEND : S_READ;
      S_ROWEND: if (row_jump) st_d = (row_q != '0) ? S_READ : S_ROWEND;
                else st_d = S_DONE;
      S_DONE:   st_d = S_NEXT;
      S_NEXT:   st_d = (enable && (next_q != '0)) ? S_FETCH : S_IDLE;
      default:  st_d = S_IDLE;
    endcase
  end

  // memory request decode
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = data_q;
    unique case (st_q)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cb_q + AW'(idx_q) * AW'(BYTES);
      end
      S_READ: begin
        mem_req  = !src_skip;
        mem_addr = cur_src;
      end
      S_WRITE: begin
        mem_req  = !dst_skip;
        mem_we   = 1'b1;
        mem_addr = cur_dst;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      idx_q    <= '0;
      cb_q     <= '0;
      info_q   <= '0;
      len_q    <= '0;
      stride_q <= '0;
      next_q   <= '0;
      data_q   <= '0;
      xrem_q   <= '0;
      row_q    <= '0;
      yrem_q   <= '0;
      end_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE || st_q == S_NEXT) idx_q <= '0;
      else if (fetch_hs)                    idx_q <= idx_q + IDX_W'(1);
      if (start_ok)             cb_q <= first_desc;
      else if (st_q == S_NEXT)  cb_q <= next_q;
      if (fetch_hs) begin
        unique case (idx_q)
          IDX_W'(W_INFO):   info_q   <= mem_rdata;
          IDX_W'(W_LEN):    len_q    <= mem_rdata;
          IDX_W'(W_STRIDE): stride_q <= mem_rdata;
          IDX_W'(W_NEXT):   next_q   <= mem_rdata;
          default: ;
        endcase
      end
      if (setup) begin
        xrem_q <= g_row_bytes;
        row_q  <= g_row_bytes;
        yrem_q <= g_rows;
      end
      if (rd_done) data_q <= src_skip ? '0 : mem_rdata;
      if (beat_done) begin
        xrem_q <= xnext;
        len_q  <= info_q[IB_ROWMODE] ? {yrem_q, xnext[ROW_W-1:0]} : xnext;
      end
      if (row_jump) begin
        yrem_q <= yrem_q - ROW_W'(1);
        xrem_q <= row_q;
      end
      if (start_ok) begin
        end_q <= 1'b0;
        irq_q <= 1'b0;
      end else if (st_q == S_DONE) begin
        end_q <= 1'b1;
        irq_q <= irq_q | info_q[IB_IRQ_EN];
      end
    end
  end

  assign busy          = (st_q != S_IDLE);
  assign desc_done     = (st_q == S_DONE);
  assign end_flag      = end_q;
  assign irq           = irq_q;
  assign cur_desc_addr = cb_q;
  assign cur_info      = info_q;
  assign cur_len       = len_q;
  assign cur_stride    = stride_q;
  assign cur_next      = next_q;

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_no_write_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !dst_skip);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

  p_irq_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(desc_done));

  p_stop_on_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_NEXT && !enable) |=> !busy);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: tb/chain_dma_test.sv
module chain_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        enable = 1'b1;
  logic [31:0] first_desc = '0;
  logic        busy, desc_done, end_flag, irq, mem_req, mem_we;
  logic [31:0] cur_desc_addr, cur_info, cur_src, cur_dst, cur_len, cur_stride, cur_next;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #10 clk = ~clk;

  chain_dma uut (
    .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .first_desc(first_desc),
    .busy(busy), .cur_desc_addr(cur_desc_addr), .cur_info(cur_info), .cur_src(cur_src),
    .cur_dst(cur_dst), .cur_len(cur_len), .cur_stride(cur_stride), .cur_next(cur_next),
    .desc_done(desc_done), .end_flag(end_flag), .irq(irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] exp_mem [0:1023];
  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, hold_err = 0, rd_log_n = 0;
  logic [31:0] rd_log [0:7];
  logic [1:0]  wait_cnt = 2'd0;
  logic [7:0]  lfsr = 8'h5B;
  logic        prev_req = 1'b0, prev_we = 1'b0, prev_ack = 1'b0;
  logic [31:0] prev_addr = '0, prev_wdata = '0;
  logic [31:0] exp_src, exp_dst, exp_len;
  int          exp_rd, exp_wr;
  int          cyc = 0;
  bit          finished = 1'b0;

  // memory model: responses are set up at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      wait_cnt  <= 2'd0;
    end else begin
      if (prev_req && !prev_ack &&
          (!mem_req || mem_addr != prev_addr || mem_we != prev_we ||
           (mem_we && mem_wdata != prev_wdata)))
        hold_err++;
      prev_req = mem_req; prev_addr = mem_addr; prev_we = mem_we;
      prev_wdata = mem_wdata; prev_ack = 1'b0;
      if (mem_ready) mem_ready <= 1'b0;
      else if (mem_req) begin
        if (wait_cnt == 2'd0) begin
          prev_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata <= mem[mem_addr[11:2]];
            rd_cnt++;
            if (rd_log_n < 8) rd_log[rd_log_n] = mem_addr;
            rd_log_n++;
          end
          mem_ready <= 1'b1;
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          wait_cnt <= lfsr[1:0];
        end else wait_cnt <= wait_cnt - 2'd1;
      end
      if (desc_done) done_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + 32'(i);
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] info, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] len,
                          input logic [31:0] stride, input logic [31:0] nxt);
    mem[a[11:2]]       = info;
    mem[a[11:2] + 10'd1] = src;
    mem[a[11:2] + 10'd2] = dst;
    mem[a[11:2] + 10'd3] = len;
    mem[a[11:2] + 10'd4] = stride;
    mem[a[11:2] + 10'd5] = nxt;
  endtask

  // reference behaviour written from the requirements
  task automatic model_desc(input logic [31:0] info, input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] len, input logic [31:0] stride);
    bit          two_d;
    int          rows;
    logic [31:0] rowb, ss, ds, s, d, l, x, data;
    two_d = info[1];
    rows  = two_d ? 1 + int'(len[29:16]) : 1;
    rowb  = two_d ? {16'd0, len[15:0]} : len;
    ss    = two_d ? {{16{stride[15]}}, stride[15:0]} : 32'd0;
    ds    = two_d ? {{16{stride[31]}}, stride[31:16]} : 32'd0;
    s = src; d = dst; l = len; exp_rd = 0; exp_wr = 0;
    for (int r = rows; r > 0; r--) begin
      x = rowb;
      while (x != 0) begin
        data = info[11] ? 32'd0 : exp_mem[s[11:2]];
        if (!info[11]) exp_rd++;
        if (!info[7]) begin exp_mem[d[11:2]] = data; exp_wr++; end
        if (info[8]) s = s + 32'd4;
        if (info[4]) d = d + 32'd4;
        x = (x > 32'd4) ? x - 32'd4 : 32'd0;
        l = two_d ? {16'(r), x[15:0]} : x;
      end
      if (r > 1) begin s = s + ss; d = d + ds; end
    end
    exp_src = s; exp_dst = d; exp_len = l;
  endtask

  task automatic run_chain(input logic [31:0] a, output bit timed_out);
    int n;
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; rd_log_n = 0;
    @(negedge clk);
    first_desc = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    timed_out = busy;
  endtask

  // info, src, dst, len, stride
  localparam logic [159:0] VEC [0:6] = '{
    {32'h0000_0111, 32'h100, 32'h200, 32'd16,        32'h0000_0000},
    {32'h0000_0810, 32'h100, 32'h280, 32'd12,        32'h0000_0000},
    {32'h0000_0180, 32'h100, 32'h200, 32'd8,         32'h0000_0000},
    {32'h0000_0113, 32'h100, 32'h2C0, 32'h0002_0008, 32'h0000_0004},
    {32'h0000_0003, 32'h180, 32'h300, 32'h0001_0008, 32'hFFF0_0010},
    {32'h0000_0000, 32'h140, 32'h340, 32'd10,        32'h0000_0000},
    {32'h0000_0001, 32'h100, 32'h200, 32'd0,         32'h0000_0000}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit to;
    bit mem_ok;
    logic [31:0] v_info, v_src, v_dst, v_len, v_str;
    fill_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req && !desc_done && !end_flag && !irq, "R1 reset idle",
        {27'd0, busy, mem_req, desc_done, end_flag, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after release", {30'd0, busy, mem_req}, 32'd0);

    // R2: start ignored when disabled or pointer zero
    put_desc(32'h40, 32'h111, 32'h100, 32'h200, 32'd16, 32'd0, 32'd0);
    enable = 1'b0;
    run_chain(32'h40, to);
    repeat (10) @(negedge clk);
    chk(!busy && rd_cnt == 0, "R2 start with enable low", 32'(rd_cnt), 32'd0);
    enable = 1'b1;
    run_chain(32'h0, to);
    repeat (10) @(negedge clk);
    chk(!busy && rd_cnt == 0, "R2 start with zero pointer", 32'(rd_cnt), 32'd0);

    // vector table
    for (int k = 0; k < 7; k++) begin
      {v_info, v_src, v_dst, v_len, v_str} = VEC[k];
      fill_mem();
      put_desc(32'h40, v_info, v_src, v_dst, v_len, v_str, 32'd0);
      for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
      model_desc(v_info, v_src, v_dst, v_len, v_str);
      run_chain(32'h40, to);
      chk(!to, $sformatf("R9 vec%0d returns idle", k), {31'd0, busy}, 32'd0);
      mem_ok = 1'b1;
      for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) mem_ok = 1'b0;
      chk(mem_ok, $sformatf("R3 R5 R6 vec%0d memory image", k), {31'd0, mem_ok}, 32'd1);
      chk(rd_cnt - 6 == exp_rd, $sformatf("R5 vec%0d data reads", k), 32'(rd_cnt - 6), 32'(exp_rd));
      chk(wr_cnt == exp_wr, $sformatf("R5 vec%0d writes", k), 32'(wr_cnt), 32'(exp_wr));
      chk(cur_src == exp_src, $sformatf("R4 R6 vec%0d src", k), cur_src, exp_src);
      chk(cur_dst == exp_dst, $sformatf("R4 R6 vec%0d dst", k), cur_dst, exp_dst);
      chk(cur_len == exp_len, $sformatf("R3 R7 vec%0d len", k), cur_len, exp_len);
      chk(done_cnt == 1 && end_flag, $sformatf("R8 vec%0d done pulse", k), 32'(done_cnt), 32'd1);
      chk(irq == v_info[0], $sformatf("R8 vec%0d irq", k), {31'd0, irq}, {31'd0, v_info[0]});
      if (k == 0) begin
        for (int w = 0; w < 6; w++)
          chk(rd_log[w] == 32'h40 + 32'(4 * w), "R2 fetch order", rd_log[w], 32'h40 + 32'(4 * w));
      end
    end

    // R9: two-block chain
    fill_mem();
    put_desc(32'h40, 32'h111, 32'h100, 32'h200, 32'd64, 32'd0, 32'h60);
    put_desc(32'h60, 32'h110, 32'h100, 32'h300, 32'd8,  32'd0, 32'd0);
    run_chain(32'h40, to);
    chk(done_cnt == 2, "R9 chain runs both blocks", 32'(done_cnt), 32'd2);
    chk(mem[10'h0C0] == 32'hA500_0040, "R9 second block copied", mem[10'h0C0], 32'hA500_0040);
    chk(cur_desc_addr == 32'd0, "R9 zero pointer ends", cur_desc_addr, 32'd0);

    // R10: drop enable inside the first block
    fill_mem();
    put_desc(32'h40, 32'h111, 32'h100, 32'h200, 32'd64, 32'd0, 32'h60);
    put_desc(32'h60, 32'h110, 32'h100, 32'h300, 32'd8,  32'd0, 32'd0);
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; rd_log_n = 0;
    @(negedge clk); first_desc = 32'h40; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (12) @(negedge clk);
    enable = 1'b0;
    for (int n = 0; n < 20000 && busy; n++) @(negedge clk);
    chk(done_cnt == 1, "R10 only current block finishes", 32'(done_cnt), 32'd1);
    chk(wr_cnt == 16, "R10 current block completes", 32'(wr_cnt), 32'd16);
    chk(mem[10'h0C0] == 32'hA500_00C0, "R10 next block untouched", mem[10'h0C0], 32'hA500_00C0);
    chk(cur_desc_addr == 32'h60, "R10 pointer loaded", cur_desc_addr, 32'h60);
    enable = 1'b1;

    chk(hold_err == 0, "R11 request held until ready", 32'(hold_err), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule